// File: doc/BRIEF.md
# Configurable Clock Crosspoint Router

This block is the digital model of a sixteen-lane bidirectional clock crosspoint. Every lane is a single bit pad with its own drive enable. A bank of sixteen 8-bit setup words, loaded one word at a time from a separate register block over a parallel write bus, decides three things for each lane. It sets whether the lane listens or drives. It sets whether the lane's internal termination is switched on, and whether its true and complement legs are swapped. For a driving lane, it also names the lane that feeds it.

A driving lane copies the received value of its chosen source lane. That value first has the source lane's own leg swap removed, then the driving lane's swap applied. The copy is purely combinational from pad to pad, so a clock passes through with no register in its path. Setup writes land on the next rising edge of the control clock. A driving lane whose chosen source is not a listening lane (including itself) cannot form a valid route. It outputs a steady 0 and raises a per-lane fault flag. The termination setting is brought out as a per-lane status bit for the pad logic.

Top module: `xpt_router`

## Requirements
- R1: While reset is held and after it is released with no write, every lane listens: `pad_drive_en`, `pad_tx`, `term_on` and `src_fault` are all zero.
- R2: A write of `cfg_data` to word `cfg_idx` with `cfg_we` high takes effect at the next rising edge of `clk` and not before; words not addressed keep their value.
- R3: Bit 7 of a lane's word sets its direction: 1 drives the lane (`pad_drive_en` bit high), 0 makes it listen (drive enable low).
- R4: Bit 6 of a lane's word appears on that lane's `term_on` bit, whether the lane listens or drives.
- R5: A driving lane with a valid source and no swaps outputs `pad_rx` of the lane named in bits 3:0, following changes of `pad_rx` in the same cycle with no clock edge.
- R6: Bit 5 swaps a lane's legs: the driven value is `pad_rx[src] XOR swap[src] XOR swap[self]`, so the swap acts on both the source lane and the driving lane.
- R7: Bit 4 is reserved; its value changes no output.
- R8: A driving lane whose source lane is itself set to drive outputs 0 and raises its `src_fault` bit.
- R9: A driving lane whose source field names the lane itself outputs 0 and raises its `src_fault` bit.
- R10: For a listening lane, bits 3:0 are ignored: its `pad_tx` and `src_fault` bits stay 0 whatever they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for setup writes |
| rst_n | input | 1 | Active-low reset, clears all setup words |
| cfg_we | input | 1 | Write strobe for one setup word |
| cfg_idx | input | 4 | Lane number of the word being written |
| cfg_data | input | 8 | Setup word: [7] drive, [6] termination, [5] leg swap, [4] reserved, [3:0] source lane |
| pad_rx | input | 16 | Value received on each lane's true leg |
| pad_tx | output | 16 | Value driven on each lane's true leg |
| pad_drive_en | output | 16 | Per-lane driver enable |
| term_on | output | 16 | Per-lane termination enable status |
| src_fault | output | 16 | Per-lane flag for a driving lane with an unusable source |

## Verification
Setup results (direction, termination, fault, routing) are due exactly one rising edge after the write strobe is sampled, while a change on `pad_rx` must show on `pad_tx` in the same cycle. The bench drives all inputs on the falling edge. It compares every output 1 ns after each rising edge, once the model and the design have both taken the write. It also compares 1 ns after each falling-edge stimulus, which catches both a write that lands early and a data path that wrongly waits for a clock.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    localparam int unsigned XPT_LANES  = 16;
    localparam int unsigned XPT_WORD_W = 8;
    localparam int unsigned XPT_SRC_W  = 4;

    // Field order is fixed by the write bus: [7] drive, [6] term, [5] swap, [4] spare, [3:0] source.
    typedef struct packed {
        logic                 drive;
        logic                 term;
        logic                 swap;
        logic                 spare;
        logic [XPT_SRC_W-1:0] src;
    } lane_cfg_t;

endpackage

// File: rtl/xpt_cfg_bank.sv
module xpt_cfg_bank
    import xpt_pkg::*;
#(
    parameter int unsigned NLANES = XPT_LANES,
    localparam int unsigned IDX_W = $clog2(NLANES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDX_W-1:0]            idx,
    input  logic [XPT_WORD_W-1:0]       wdata,
    output lane_cfg_t [NLANES-1:0]      cfg_o
);

    typedef struct packed {
        lane_cfg_t [NLANES-1:0] word;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NLANES; k++) begin
            if (we && (idx == IDX_W'(k))) begin
                st_d.word[k] = lane_cfg_t'(wdata);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.word;

    for (genvar g = 0; g < NLANES; g++) begin : g_word_chk
        // R2
        wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && idx == IDX_W'(g)) |=> (cfg_o[g] == lane_cfg_t'($past(wdata))));
        // R2
        wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && idx == IDX_W'(g)) |=> $stable(cfg_o[g]));
    end

endmodule

// File: rtl/xpt_lane_route.sv
module xpt_lane_route
    import xpt_pkg::*;
#(
    parameter int unsigned NLANES = XPT_LANES,
    parameter int unsigned SELF   = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  lane_cfg_t [NLANES-1:0] cfg,
    input  logic [NLANES-1:0]      rx_norm,
    output logic                   tx_o,
    output logic                   oe_o,
    output logic                   term_o,
    output logic                   fault_o
);

    logic [XPT_SRC_W-1:0] pick;
    logic                 pick_busy;
    logic                 pick_self;

    always_comb begin
        pick      = cfg[SELF].src;
        pick_busy = cfg[pick].drive;
        pick_self = (pick == XPT_SRC_W'(SELF));
        oe_o      = cfg[SELF].drive;
        term_o    = cfg[SELF].term;
        fault_o   = oe_o && (pick_busy || pick_self);
        if (oe_o && !fault_o) begin
            tx_o = rx_norm[pick] ^ cfg[SELF].swap;
        end else begin
            tx_o = 1'b0;
        end
    end

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> (!tx_o && !fault_o));
    // R8
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !tx_o);
    // R9
    self_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && pick == XPT_SRC_W'(SELF)) |-> fault_o);

endmodule

// File: rtl/xpt_router.sv
module xpt_router
    import xpt_pkg::*;
#(
    parameter int unsigned NLANES = XPT_LANES,
    localparam int unsigned IDX_W = $clog2(NLANES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [XPT_WORD_W-1:0] cfg_data,
    input  logic [NLANES-1:0]     pad_rx,
    output logic [NLANES-1:0]     pad_tx,
    output logic [NLANES-1:0]     pad_drive_en,
    output logic [NLANES-1:0]     term_on,
    output logic [NLANES-1:0]     src_fault
);

    lane_cfg_t [NLANES-1:0] cfg;
    logic [NLANES-1:0]      rx_norm;

    xpt_cfg_bank #(.NLANES(NLANES)) bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (cfg_data),
        .cfg_o (cfg)
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign rx_norm[g] = pad_rx[g] ^ cfg[g].swap;

        xpt_lane_route #(.NLANES(NLANES), .SELF(g)) route_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (cfg),
            .rx_norm (rx_norm),
            .tx_o    (pad_tx[g]),
            .oe_o    (pad_drive_en[g]),
            .term_o  (term_on[g]),
            .fault_o (src_fault[g])
        );
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_drive_en == '0 && term_on == '0 && src_fault == '0 && pad_tx == '0));
    // R3
    drive_only_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && $past(!cfg_we)) |-> $stable(pad_drive_en));

endmodule

// File: tb/xpt_router_tb_top.sv
`timescale 1ns/1ps
module xpt_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_data = '0;
    logic [15:0] pad_rx = '0;
    logic [15:0] pad_tx, pad_drive_en, term_on, src_fault;

    int errors = 0;
    int checks = 0;
    bit live = 1'b0;

    always #2.5 clk = ~clk;

    xpt_router dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .pad_rx(pad_rx), .pad_tx(pad_tx),
        .pad_drive_en(pad_drive_en), .term_on(term_on), .src_fault(src_fault)
    );

    // Behavioural model: a table of words, written on the rising edge.
    logic [7:0] mdl [16];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mdl[i] <= 8'h00;
        end else if (cfg_we) begin
            mdl[cfg_idx] <= cfg_data;
        end
    end

    logic [15:0] e_tx, e_oe, e_term, e_flt;
    always_comb begin
        e_tx = '0; e_oe = '0; e_term = '0; e_flt = '0;
        for (int p = 0; p < 16; p++) begin
            logic [7:0] w;
            int s;
            w = mdl[p];
            s = int'(w[3:0]);
            e_term[p] = w[6];
            e_oe[p]   = w[7];
            if (w[7]) begin
                if (mdl[s][7] || s == p) e_flt[p] = 1'b1;
                else e_tx[p] = pad_rx[s] ^ mdl[s][5] ^ w[5];
            end
        end
    end

    task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        cmp(tag, "pad_drive_en", pad_drive_en, e_oe);
        cmp(tag, "term_on", term_on, e_term);
        cmp(tag, "src_fault", src_fault, e_flt);
        cmp(tag, "pad_tx", pad_tx, e_tx);
    endtask

    // Per-cycle comparison, 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (live) check_all("R3 R4 R6 R8 R9 R10 per-cycle");
    end

    task automatic wr(logic [3:0] i, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = i; cfg_data = d;
        #1 check_all("R2 before edge");
        @(negedge clk);
        cfg_we = 1'b0;
        #1 check_all("R2 after edge");
    endtask

    task automatic drive_rx(logic [15:0] v, string tag);
        @(negedge clk);
        pad_rx = v;
        #1 check_all(tag);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 check_all("R1 in reset");
        rst_n = 1'b1;
        live  = 1'b1;
        @(negedge clk);
        #1 check_all("R1 after release");

        // R5: plain route lane 2 -> lane 3, combinational follow
        wr(4'd3, 8'h82);
        drive_rx(16'h0004, "R5 rx high");
        drive_rx(16'h0000, "R5 rx low");
        drive_rx(16'hFFFB, "R5 other lanes high");
        // fan out to more lanes
        wr(4'd5, 8'h82);
        wr(4'd9, 8'h86);
        drive_rx(16'h0044, "R5 fan-out");
        drive_rx(16'h0040, "R5 fan-out mix");

        // R4: termination on listening and driving lanes
        wr(4'd6, 8'h40);
        wr(4'd5, 8'hC2);
        drive_rx(16'h0004, "R4 term status");

        // R6: swap on source, on destination, on both
        wr(4'd2, 8'h20);
        drive_rx(16'h0004, "R6 source swap");
        wr(4'd3, 8'hA2);
        drive_rx(16'h0000, "R6 both swapped");
        drive_rx(16'h0004, "R6 both swapped rx1");
        wr(4'd9, 8'hA6);
        drive_rx(16'h0040, "R6 dest swap");

        // R7: reserved bit set on a driver and a listener
        wr(4'd8, 8'h92);
        wr(4'd6, 8'h50);
        drive_rx(16'h0000, "R7 reserved bit");
        drive_rx(16'h0044, "R7 reserved bit rx1");

        // R8: source is a driving lane
        wr(4'd11, 8'h83);
        drive_rx(16'hFFFF, "R8 busy source");
        // R8: source turns from listener into driver
        wr(4'd12, 8'h86);
        drive_rx(16'h0040, "R8 before source flips");
        wr(4'd6, 8'h80);
        drive_rx(16'hFFFF, "R8 after source flips");

        // R9: lane picks itself
        wr(4'd13, 8'h8D);
        drive_rx(16'hFFFF, "R9 self source");

        // R10: listening lane with junk source field
        wr(4'd14, 8'h0F);
        wr(4'd15, 8'h3E);
        drive_rx(16'hFFFF, "R10 listener ignores source");

        // walking pattern over the whole map
        for (int k = 0; k < 16; k++) drive_rx(16'h1 << k, "R5 R6 walking rx");

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        live  = 1'b0;
        #1 check_all("R1 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;
        #1 check_all("R1 after second release");
        repeat (2) @(negedge clk);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule